// File: doc/BRIEF.md
# Striped XOR Parity Engine

This block does the parity arithmetic for a small striped disk array with distributed parity. The array has `N` members. Each stripe row holds `N-1` data strips and one parity strip. The engine handles one word per command and has four operations:

- It computes a full-stripe parity word.
- It updates parity after a single data word changes, using the read-modify-write shortcut.
- It rebuilds the word of a failed member from the survivors.
- It translates a logical strip number into a stripe row and a physical disk.

The parity strip moves from stripe to stripe, so no single member carries all the parity traffic. For stripe `s`, parity sits on disk `(N-1) - (s mod N)`, and the data strips fill the remaining disks in ascending order. Commands use a valid/ready handshake. The result comes out one cycle later together with the disk index it belongs to.

Top module: `raid_parity_engine`

## Requirements
- R1: During reset and in the first cycle after it, `res_valid` is 0 and `cmd_ready` is 1.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `res_valid` is 1 in exactly the cycle after each acceptance, and it is 0 otherwise. `cmd_ready` is 0 whenever `res_valid` is 1.
- R3: Op code 2'b00 (generate) returns the XOR of operand slots 0 to N-2. Slot `k` occupies bits `[k*W +: W]` of `cmd_opnd`. Slot N-1 has no effect on the result.
- R4: For generate and small-write, `res_disk` is the parity disk of stripe `cmd_addr`, which is `(N-1) - (cmd_addr mod N)`. Over any N consecutive stripes, each disk holds parity exactly once.
- R5: Op code 2'b01 (small-write) returns slot0 XOR slot1 XOR slot2. Slot 0 is the old data, slot 1 the old parity and slot 2 the new data. Slots 3 and above have no effect.
- R6: Op code 2'b10 (reconstruct) returns the XOR of every slot except slot `cmd_disk`, where slots are indexed by physical disk. The content of slot `cmd_disk` has no effect, and `res_disk` equals `cmd_disk`.
- R7: Op code 2'b11 (map) treats `cmd_addr` as a logical strip number `L`. `res_data` is the zero-extended stripe row `L / (N-1)`. `res_disk` is the physical disk that holds data position `L mod (N-1)` in that row, counted in ascending order over the disks that do not hold parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | AW | Stripe row, or logical strip number for map |
| cmd_disk | input | $clog2(N) | Failed member for reconstruct |
| cmd_opnd | input | N*W | N operand word slots |
| res_valid | output | 1 | Result present |
| res_data | output | W | Result word, or stripe row for map |
| res_disk | output | $clog2(N) | Disk the result targets |

## Verification
Generate commands run over stripes 0 to 2N with random words, including a random word in the unused last slot. This shows whether the XOR takes in the right slots and whether parity placement cycles through every disk. Small-write commands carry random words in the unused upper slots, and reconstruct commands name each member in turn with random words in the failed slot, so a design that reads a slot it should ignore gives a wrong result. Map commands cover every logical strip across two full rotations, which separates the data positions before the parity disk from those after it. A command held valid during the pending-result cycle checks the throttling.

// File: rtl/raid_parity_engine.sv
module raid_parity_engine #(
  parameter int W  = 16,
  parameter int N  = 5,
  parameter int AW = 16,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [IW-1:0]   cmd_disk,
  input  logic [N*W-1:0]  cmd_opnd,
  output logic            res_valid,
  output logic [W-1:0]    res_data,
  output logic [IW-1:0]   res_disk
);

  logic          accept;
  logic [W-1:0]  nxt_data;
  logic [IW-1:0] nxt_disk;
  int            pd, row, pos;

  assign cmd_ready = !res_valid;
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    nxt_data = '0;
    nxt_disk = '0;
    pd  = (N - 1) - int'(cmd_addr % N);
    row = int'(cmd_addr / (N - 1));
    pos = int'(cmd_addr % (N - 1));
    case (cmd_op)
      2'b00: begin
        for (int i = 0; i < N - 1; i++) nxt_data ^= cmd_opnd[i*W +: W];
        nxt_disk = IW'(pd);
      end
      2'b01: begin
        nxt_data = cmd_opnd[0 +: W] ^ cmd_opnd[W +: W] ^ cmd_opnd[2*W +: W];
        nxt_disk = IW'(pd);
      end
      2'b10: begin
        for (int i = 0; i < N; i++)
          if (i != int'(cmd_disk)) nxt_data ^= cmd_opnd[i*W +: W];
        nxt_disk = cmd_disk;
      end
      default: begin
        pd       = (N - 1) - (row % N);
        nxt_data = W'(row);
        nxt_disk = (pos < pd) ? IW'(pos) : IW'(pos + 1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_disk  <= '0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_data <= nxt_data;
        res_disk <= nxt_disk;
      end
    end
  end

endmodule

// File: rtl/raid_parity_engine_chk.sv
module raid_parity_engine_chk #(
  parameter int W  = 16,
  parameter int N  = 5,
  parameter int AW = 16,
  localparam int IW = $clog2(N)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [1:0]     cmd_op,
  input logic [AW-1:0]  cmd_addr,
  input logic [IW-1:0]  cmd_disk,
  input logic [N*W-1:0] cmd_opnd,
  input logic           res_valid,
  input logic [W-1:0]   res_data,
  input logic [IW-1:0]  res_disk
);

  logic take;
  assign take = cmd_valid && cmd_ready;

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (!res_valid && cmd_ready)); // R1
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) take |=> res_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !take |=> !res_valid); // R2
  AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> !cmd_ready); // R2
  AST_GEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == 2'b00) |=> res_disk == IW'((N - 1) - int'($past(cmd_addr) % N))); // R4
  AST_SMALL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == 2'b01) |=> res_data == ($past(cmd_opnd[0 +: W]) ^ $past(cmd_opnd[W +: W]) ^ $past(cmd_opnd[2*W +: W]))); // R5
  AST_RECON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == 2'b10) |=> res_disk == $past(cmd_disk)); // R6

endmodule

bind raid_parity_engine raid_parity_engine_chk #(.W(W), .N(N), .AW(AW)) u_chk (.*);

// File: tb/raid_parity_engine_test.sv
module raid_parity_engine_test;
  localparam int W = 16, N = 5, AW = 16, IW = $clog2(N);

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [IW-1:0] cmd_disk = 0;
  logic [N*W-1:0] cmd_opnd = 0;
  logic cmd_ready, res_valid;
  logic [W-1:0] res_data;
  logic [IW-1:0] res_disk;

  int errors = 0, checks = 0;
  bit exp_valid = 0;
  int exp_data = 0, exp_disk = 0;
  string exp_req = "R1";

  always #5 clk = ~clk;

  raid_parity_engine #(.W(W), .N(N), .AW(AW)) uut (.*);

  function automatic int slot(int k);
    return int'(cmd_opnd[k*W +: W]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid = 0; exp_req = "R1";
    end else if (cmd_valid && !exp_valid) begin
      int stripe, pdisk, seen;
      exp_valid = 1;
      exp_data = 0;
      stripe = int'(cmd_addr);
      pdisk = (N - 1) - (stripe % N);
      case (cmd_op)
        2'b00: begin
          for (int k = 0; k <= N - 2; k++) exp_data = exp_data ^ slot(k);
          exp_disk = pdisk; exp_req = "R3/R4";
        end
        2'b01: begin
          exp_data = slot(2) ^ slot(1) ^ slot(0);
          exp_disk = pdisk; exp_req = "R5/R4";
        end
        2'b10: begin
          for (int k = N - 1; k >= 0; k--) if (k != int'(cmd_disk)) exp_data = exp_data ^ slot(k);
          exp_disk = int'(cmd_disk); exp_req = "R6";
        end
        default: begin
          stripe = int'(cmd_addr) / (N - 1);
          pdisk = (N - 1) - (stripe % N);
          exp_data = stripe;
          seen = -1;
          for (int d = 0; d < N; d++) begin
            if (d != pdisk) seen++;
            if (d != pdisk && seen == int'(cmd_addr) % (N - 1)) begin exp_disk = d; break; end
          end
          exp_req = "R7";
        end
      endcase
    end else begin
      exp_valid = 0; exp_req = rst_n ? "R2" : "R1";
    end
  end

  always @(negedge clk) begin
    checks++;
    if (res_valid !== exp_valid || cmd_ready !== !exp_valid) begin
      errors++;
      $display("FAIL %s handshake: valid=%b ready=%b expected valid=%b ready=%b",
               exp_valid ? "R2" : exp_req, res_valid, cmd_ready, exp_valid, !exp_valid);
    end
    if (exp_valid) begin
      checks++;
      if (int'(res_data) != (exp_data & ((1 << W) - 1)) || int'(res_disk) != exp_disk) begin
        errors++;
        $display("FAIL %s result: data=%h disk=%0d expected data=%h disk=%0d",
                 exp_req, res_data, res_disk, exp_data[W-1:0], exp_disk);
      end
    end
  end

  task automatic issue(input logic [1:0] op, input int addr, input int disk);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = AW'(addr); cmd_disk = IW'(disk);
    for (int k = 0; k < N; k++) cmd_opnd[k*W +: W] = W'($urandom);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int s = 0; s <= 2 * N; s++) issue(2'b00, s, 0);          // R3 R4
    for (int s = 0; s < 8; s++) issue(2'b01, s * 3, 0);           // R5
    for (int d = 0; d < N; d++) issue(2'b10, d, d);               // R6
    for (int l = 0; l < 2 * N * (N - 1); l++) issue(2'b11, l, 0); // R7
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b10; cmd_disk = 1;                  // R2 held valid
    repeat (4) @(negedge clk);
    cmd_valid = 0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule